// File: doc/BRIEF.md
# Oversampling Serial Character Receiver

This block recovers asynchronous serial characters from a single line using a one-cycle 16x baud enable. The line (or, in loopback, an internal transmit line) passes through a two-flop synchronizer. A falling level is taken as a candidate start bit. The start bit is confirmed at its midpoint, and every later bit is sampled sixteen enable pulses after the previous one. The receiver handles 5 to 8 data bits, optional normal or stick parity and one checked stop bit. Each finished character leaves on a stream output with parity-error, framing-error and break tags, ready to be written into a receive FIFO.

The output follows valid/ready rules adapted to a source that cannot stall: a serial line cannot be paused. A finished character is offered for exactly one clock. `m_valid` is raised in that cycle only if `m_ready` (FIFO not full) is high, and the transfer happens on that cycle. If `m_ready` is low in that cycle, the character is dropped and `overrun` pulses instead, so the FIFO contents are left as they were. The receiver keeps hunting for new characters, and a later character only refills its own shift register. The configuration inputs must be held steady while a character is being received.

Top module: `uart_rx_core`

## Requirements
- R1: After reset, `m_valid` and `overrun` are low until a character completes.
- R2: With `word_len`=11 and parity off, a frame of start, 8 data bits sent LSB first and stop produces one `m_valid` pulse whose `m_data` equals the sent byte, with all tags 0.
- R3: `word_len` selects the data bit count: 00=5, 01=6, 10=7, 11=8. Unreceived upper bits of `m_data` read 0.
- R4: With `par_en`=1 and `par_stick`=0, the expected parity bit makes the total count of ones (data plus parity) even when `par_even`=1 and odd when `par_even`=0. A mismatch sets `m_perr`. With `par_en`=0, `m_perr` stays 0.
- R5: With `par_en`=1 and `par_stick`=1, the expected parity bit is 0 when `par_even`=1 and 1 when `par_even`=0.
- R6: Only the first stop bit is checked. A stop sample of 0 sets `m_ferr`, and the receiver then waits for the line to be high before it accepts a new start bit.
- R7: A line held at 0 through a whole character time (start, data, parity if enabled, stop) yields exactly one character with `m_data`=0, `m_brk`=1, `m_ferr`=1 and `m_perr`=0. No further character follows until the line has gone high and a new start bit arrives.
- R8: A character that completes while `m_ready` is low raises `overrun` for one cycle and leaves `m_valid` low. The same holds for each such character, and reception resumes normally once `m_ready` is high.
- R9: A low pulse shorter than half a bit time is rejected as a glitch, and no character is produced.
- R10: When `loop_en`=1, the receiver takes its line from `loop_rxd`, and `rxd` has no effect.
- R11: While `div_zero`=1, baud enables are ignored: no sampling takes place and no character or overrun is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | One-cycle pulse at 16x the baud rate |
| div_zero | input | 1 | Baud divisor is zero; sampling halted |
| rxd | input | 1 | Serial input line, idle high |
| loop_en | input | 1 | Select internal loopback line |
| loop_rxd | input | 1 | Internal transmit line used in loopback |
| word_len | input | 2 | Data bits: 00=5, 01=6, 10=7, 11=8 |
| par_en | input | 1 | Parity bit present and checked |
| par_even | input | 1 | 1 = even parity, 0 = odd |
| par_stick | input | 1 | Parity bit fixed at a constant value |
| m_ready | input | 1 | Downstream FIFO can accept a character |
| m_valid | output | 1 | Character transferred this cycle |
| m_data | output | 8 | Received data, LSB = first bit |
| m_perr | output | 1 | Parity error tag |
| m_ferr | output | 1 | Framing error tag |
| m_brk | output | 1 | Break tag |
| overrun | output | 1 | Character lost because `m_ready` was low |

## Verification
A wrong bit counter or sample phase shows within one character time: it produces shifted data bits or a false framing error on the next frame. A stuck break or framing wait state shows as missing characters after the line has recovered. A corrupted parity accumulator shows as a wrong `m_perr` on the very character it affects. The scoreboard holds the expected tags and data for every frame, so it catches both a wrong field and an unexpected or missing pulse. It also checks that overrun is reported instead of `m_valid` while `m_ready` is low.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int DATA_W   = 8;
  localparam int MIN_BITS = 5;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_START = 3'd1,
    S_DATA  = 3'd2,
    S_PAR   = 3'd3,
    S_STOP  = 3'd4,
    S_WAIT  = 3'd5
  } rx_state_t;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rxd,
  input  logic loop_rxd,
  input  logic loop_en,
  output logic rx_s
);
  logic [STAGES-1:0] sr_q;
  logic              line;

  assign line = loop_en ? loop_rxd : rxd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '1;
    else        sr_q <= {sr_q[STAGES-2:0], line};
  end

  assign rx_s = sr_q[STAGES-1];
endmodule

// File: rtl/uart_rx_parity.sv
module uart_rx_parity #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] bits,
  input  logic          par_even,
  input  logic          par_stick,
  output logic          exp_bit
);
  always_comb begin
    if (par_stick)     exp_bit = ~par_even;
    else if (par_even) exp_bit = ^bits;
    else               exp_bit = ~^bits;
  end
endmodule

// File: rtl/uart_rx_fsm.sv
module uart_rx_fsm
  import uart_rx_pkg::*;
#(
  parameter int OSR = 16,
  parameter int DW  = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tk,
  input  logic          rx_s,
  input  logic [1:0]    word_len,
  input  logic          par_en,
  input  logic          exp_par,
  output logic [DW-1:0] shf,
  output logic          done_q,
  output logic [DW-1:0] data_q,
  output logic          perr_q,
  output logic          ferr_q,
  output logic          brk_q
);
  localparam int CW   = $clog2(OSR);
  localparam int IW   = $clog2(DW);
  localparam int HALF = OSR / 2;

  rx_state_t     st_q;
  logic [CW-1:0] ctr_q;
  logic [IW-1:0] idx_q;
  logic          one_q;
  logic          pe_q;
  logic [IW-1:0] last_idx;
  logic          mid;
  logic          brk_now;

  assign last_idx = IW'(MIN_BITS - 1) + IW'(word_len);
  assign mid      = (ctr_q == CW'(OSR - 1));
  assign brk_now  = !one_q && !rx_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      ctr_q  <= '0;
      idx_q  <= '0;
      shf    <= '0;
      one_q  <= 1'b0;
      pe_q   <= 1'b0;
      done_q <= 1'b0;
      data_q <= '0;
      perr_q <= 1'b0;
      ferr_q <= 1'b0;
      brk_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (tk) begin
        unique case (st_q)
          S_IDLE: begin
            if (!rx_s) begin
              st_q  <= S_START;
              ctr_q <= '0;
            end
          end
          S_START: begin
            if (ctr_q == CW'(HALF - 1)) begin
              ctr_q <= '0;
              if (!rx_s) begin
                st_q  <= S_DATA;
                idx_q <= '0;
                shf   <= '0;
                one_q <= 1'b0;
                pe_q  <= 1'b0;
              end else begin
                st_q <= S_IDLE;
              end
            end else begin
              ctr_q <= ctr_q + CW'(1);
            end
          end
          S_DATA: begin
            if (mid) begin
              ctr_q      <= '0;
              shf[idx_q] <= rx_s;
              one_q      <= one_q | rx_s;
              if (idx_q == last_idx) st_q <= par_en ? S_PAR : S_STOP;
              else                   idx_q <= idx_q + IW'(1);
            end else begin
              ctr_q <= ctr_q + CW'(1);
            end
          end
          S_PAR: begin
            if (mid) begin
              ctr_q <= '0;
              pe_q  <= (rx_s != exp_par);
              one_q <= one_q | rx_s;
              st_q  <= S_STOP;
            end else begin
              ctr_q <= ctr_q + CW'(1);
            end
          end
          S_STOP: begin
            if (mid) begin
              ctr_q  <= '0;
              done_q <= 1'b1;
              data_q <= shf;
              ferr_q <= !rx_s;
              brk_q  <= brk_now;
              perr_q <= brk_now ? 1'b0 : pe_q;
              st_q   <= rx_s ? S_IDLE : S_WAIT;
            end else begin
              ctr_q <= ctr_q + CW'(1);
            end
          end
          S_WAIT: begin
            if (rx_s) st_q <= S_IDLE;
          end
          default: st_q <= S_IDLE;
        endcase
      end
    end
  end

  // R7
  brk_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && brk_q) |-> (data_q == '0 && ferr_q && !perr_q));

  // R6
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_WAIT && !rx_s) |=> (st_q == S_WAIT));

  // R3
  len5_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && $past(word_len) == 2'b00 && word_len == 2'b00)
      |-> (data_q[DW-1:MIN_BITS] == '0));
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
  import uart_rx_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic              div_zero,
  input  logic              rxd,
  input  logic              loop_en,
  input  logic              loop_rxd,
  input  logic [1:0]        word_len,
  input  logic              par_en,
  input  logic              par_even,
  input  logic              par_stick,
  input  logic              m_ready,
  output logic              m_valid,
  output logic [DATA_W-1:0] m_data,
  output logic              m_perr,
  output logic              m_ferr,
  output logic              m_brk,
  output logic              overrun
);
  logic              rx_s;
  logic              tk;
  logic              exp_par;
  logic [DATA_W-1:0] shf;
  logic              done_q;

  assign tk = tick16 & ~div_zero;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .rxd      (rxd),
    .loop_rxd (loop_rxd),
    .loop_en  (loop_en),
    .rx_s     (rx_s)
  );

  uart_rx_parity #(.DW(DATA_W)) u_par (
    .bits      (shf),
    .par_even  (par_even),
    .par_stick (par_stick),
    .exp_bit   (exp_par)
  );

  uart_rx_fsm #(.OSR(OSR), .DW(DATA_W)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .tk       (tk),
    .rx_s     (rx_s),
    .word_len (word_len),
    .par_en   (par_en),
    .exp_par  (exp_par),
    .shf      (shf),
    .done_q   (done_q),
    .data_q   (m_data),
    .perr_q   (m_perr),
    .ferr_q   (m_ferr),
    .brk_q    (m_brk)
  );

  assign m_valid = done_q & m_ready;
  assign overrun = done_q & ~m_ready;

  // R11
  halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_zero |=> (!m_valid && !overrun));

  // R4
  no_perr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !par_en && !$past(par_en)) |-> !m_perr);
endmodule

// File: tb/uart_rx_core_tb.sv
module uart_rx_core_tb;
  localparam int BITCLK = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b0;
  logic       div_zero = 1'b0;
  logic       rxd = 1'b1;
  logic       loop_en = 1'b0;
  logic       loop_rxd = 1'b1;
  logic [1:0] word_len = 2'b11;
  logic       par_en = 1'b0;
  logic       par_even = 1'b0;
  logic       par_stick = 1'b0;
  logic       m_ready = 1'b1;
  logic       m_valid;
  logic [7:0] m_data;
  logic       m_perr;
  logic       m_ferr;
  logic       m_brk;
  logic       overrun;

  typedef struct {
    logic [7:0] d;
    bit         pe;
    bit         fe;
    bit         bk;
    bit         ov;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   fails  = 0;
  bit   finished = 1'b0;

  always #2 clk = ~clk;

  uart_rx_core u_dut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .div_zero(div_zero),
    .rxd(rxd), .loop_en(loop_en), .loop_rxd(loop_rxd), .word_len(word_len),
    .par_en(par_en), .par_even(par_even), .par_stick(par_stick),
    .m_ready(m_ready), .m_valid(m_valid), .m_data(m_data), .m_perr(m_perr),
    .m_ferr(m_ferr), .m_brk(m_brk), .overrun(overrun)
  );

  initial begin
    forever begin
      repeat (3) @(negedge clk);
      tick16 = 1'b1;
      @(negedge clk);
      tick16 = 1'b0;
    end
  end

  task automatic drive_line(input logic b);
    if (loop_en) loop_rxd = b;
    else         rxd = b;
  endtask

  task automatic bit_time(input logic b);
    drive_line(b);
    repeat (BITCLK) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input bit bad_par, input bit stop_v,
                      input bit expect_out, input string tag);
    int         nb;
    logic [7:0] md;
    logic       pb;
    exp_t       e;
    nb = 5 + int'(word_len);
    md = d & 8'((1 << nb) - 1);
    if (par_stick)     pb = ~par_even;
    else if (par_even) pb = ^md;
    else               pb = ~^md;
    if (bad_par) pb = ~pb;
    e.d   = md;
    e.pe  = par_en && bad_par;
    e.fe  = !stop_v;
    e.bk  = 1'b0;
    e.ov  = !m_ready;
    e.tag = tag;
    if (expect_out) q.push_back(e);
    bit_time(1'b0);
    for (int i = 0; i < nb; i++) bit_time(md[i]);
    if (par_en) bit_time(pb);
    bit_time(stop_v);
    bit_time(1'b1);
    bit_time(1'b1);
  endtask

  task automatic chk(input bit ok, input string tag, input string msg);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s", tag, msg);
    end
  endtask

  // Scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && (m_valid || overrun)) begin
        if (q.size() == 0) begin
          chk(1'b0, "R9", $sformatf("unexpected output valid=%0b ovr=%0b data=%02h, expected none",
                                     m_valid, overrun, m_data));
        end else begin
          exp_t e;
          e = q.pop_front();
          if (e.ov)
            chk(overrun && !m_valid, e.tag,
                $sformatf("valid=%0b ovr=%0b expected valid=0 ovr=1", m_valid, overrun));
          else
            chk(m_valid && !overrun && m_data == e.d && m_perr == e.pe &&
                m_ferr == e.fe && m_brk == e.bk, e.tag,
                $sformatf("got v=%0b o=%0b d=%02h pe=%0b fe=%0b bk=%0b exp d=%02h pe=%0b fe=%0b bk=%0b",
                          m_valid, overrun, m_data, m_perr, m_ferr, m_brk,
                          e.d, e.pe, e.fe, e.bk));
        end
      end
    end
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired, queue=%0d expected 0", q.size());
      summary();
    end
  end

  initial begin
    exp_t bk;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    // R1: quiet outputs after reset
    repeat (40) begin
      @(negedge clk);
      if (m_valid || overrun) break;
    end
    chk(!m_valid, "R1", $sformatf("m_valid=%0b expected 0", m_valid));
    chk(!overrun, "R1", $sformatf("overrun=%0b expected 0", overrun));
    bit_time(1'b1);

    // R2: 8N1 patterns
    send(8'hA5, 0, 1, 1, "R2");
    send(8'h3C, 0, 1, 1, "R2");
    send(8'hFF, 0, 1, 1, "R2");
    send(8'h01, 0, 1, 1, "R2");

    // R3: word lengths
    word_len = 2'b00; send(8'hFF, 0, 1, 1, "R3");
    word_len = 2'b01; send(8'hC3, 0, 1, 1, "R3");
    word_len = 2'b10; send(8'h7E, 0, 1, 1, "R3");
    word_len = 2'b11;

    // R4: normal parity, even then odd
    par_en = 1'b1; par_even = 1'b1;
    send(8'h5A, 0, 1, 1, "R4");
    send(8'h5B, 1, 1, 1, "R4");
    par_even = 1'b0;
    send(8'h5A, 0, 1, 1, "R4");
    send(8'h11, 1, 1, 1, "R4");

    // R5: stick parity
    par_stick = 1'b1; par_even = 1'b1;
    send(8'h33, 0, 1, 1, "R5");
    send(8'h33, 1, 1, 1, "R5");
    par_even = 1'b0;
    send(8'h34, 0, 1, 1, "R5");
    par_stick = 1'b0; par_en = 1'b0;

    // R6: framing error, then recovery
    send(8'h96, 0, 0, 1, "R6");
    send(8'h42, 0, 1, 1, "R6");

    // R7: long break gives exactly one tagged zero character
    bk.d = 8'h00; bk.pe = 0; bk.fe = 1; bk.bk = 1; bk.ov = 0; bk.tag = "R7";
    q.push_back(bk);
    repeat (20) bit_time(1'b0);
    repeat (2) bit_time(1'b1);
    send(8'h24, 0, 1, 1, "R7");

    // R8: overrun while not ready
    m_ready = 1'b0;
    send(8'h11, 0, 1, 1, "R8");
    send(8'h22, 0, 1, 1, "R8");
    m_ready = 1'b1;
    send(8'h33, 0, 1, 1, "R8");

    // R9: short glitch rejected
    rxd = 1'b0;
    repeat (12) @(negedge clk);
    rxd = 1'b1;
    repeat (3) bit_time(1'b1);
    send(8'h44, 0, 1, 1, "R9");

    // R10: loopback ignores rxd
    loop_rxd = 1'b1;
    loop_en  = 1'b1;
    rxd      = 1'b0;
    bit_time(1'b1);
    send(8'hC9, 0, 1, 1, "R10");
    rxd = 1'b1;
    bit_time(1'b1);
    loop_en = 1'b0;
    bit_time(1'b1);

    // R11: halted while divisor zero
    div_zero = 1'b1;
    send(8'h55, 0, 1, 0, "R11");
    div_zero = 1'b0;
    bit_time(1'b1);
    send(8'h66, 0, 1, 1, "R11");

    repeat (4) bit_time(1'b1);
    chk(q.size() == 0, "R2", $sformatf("pending=%0d expected 0", q.size()));
    finished = 1'b1;
    summary();
  end
endmodule